// File: doc/BRIEF.md
# Link Frame Realigning Demultiplexer

This block sits on the recovered receive clock of a single serial link. Each clock it takes one 16-bit half-word from the deserializer together with two status pins: a data-valid line and an error line. Together these two pins say whether the half-word is payload, an idle filler, a carrier-extend marker or an error. The sender splits each 32-bit bunch-crossing word into two consecutive 16-bit frames, and the payload itself carries no frame marker. The block therefore takes frame phase from the link: the first payload half-word after an idle stretch is treated as the first frame of bunch crossing zero. From that point half-words are paired in order.

Each completed pair is presented as one 32-bit word with a one-cycle valid strobe. A crossing-zero marker goes with the first word built after each realignment. The block also reports the class of every received half-word and keeps two sticky flags. One records link errors, including a pair broken by a carrier extend. The other records control half-words whose content does not match the expected fixed codes. Both flags stay set until reset.

Top module: `link_frame_demux`

## Requirements
- R1: `link_class` shows the class of the half-word sampled on the previous clock edge, coded 0 for idle (valid low, error low), 1 for payload (valid high, error low), 2 for carrier extend (valid low, error high) and 3 for error (both high).
- R2: After reset, payload half-words that arrive before the first idle half-word are ignored and produce no output word.
- R3: The first payload half-word after an idle half-word is frame 1 and the next payload half-word is frame 2. The word is presented as frame 1 in bits 31:16 and frame 2 in bits 15:0, with `word_valid` high for exactly one cycle, one cycle after frame 2 is sampled.
- R4: `word_bc0` is high together with `word_valid` for the first word completed after each idle period, and low at every other time.
- R5: After the first pair, further payload half-words continue to pair in arrival order. A carrier-extend half-word that falls between two pairs does not disturb the pairing.
- R6: An idle half-word that arrives while a frame 1 is held discards that frame and re-arms alignment, so the next payload half-word starts a new pair. It does not set `err_sticky`.
- R7: A carrier-extend half-word that arrives while a frame 1 is held discards that frame and sets `err_sticky` one cycle later.
- R8: An error half-word sets `err_sticky` one cycle later at any time and discards any held frame 1, without changing the alignment state.
- R9: `err_sticky` and `code_sticky` stay high once set until a reset.
- R10: `code_sticky` is set one cycle after an idle half-word whose data is neither 0xBCC5 nor 0xBC50, or a carrier-extend half-word whose data is not 0xF7F7. Data carried with error or payload half-words never sets it.
- R11: A synchronous active-low reset clears `link_class`, `word_data`, `word_valid`, `word_bc0`, `err_sticky` and `code_sticky` to zero and returns alignment to waiting for idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rxd | input | 16 | Deserialized half-word |
| rx_dv | input | 1 | Data-valid status pin |
| rx_er | input | 1 | Error status pin |
| link_class | output | 2 | Class of the last sampled half-word |
| word_data | output | 32 | Assembled word, frame 1 in the upper half |
| word_valid | output | 1 | One-cycle strobe for a new assembled word |
| word_bc0 | output | 1 | Marks the first word after realignment |
| err_sticky | output | 1 | Sticky link-error flag |
| code_sticky | output | 1 | Sticky control-code mismatch flag |

## Verification
The delicate case is a non-payload half-word landing in the frame 2 slot. In that one cycle the block must drop the held frame, suppress the word that would have completed, and either re-arm alignment (idle) or raise the error flag (extend or error). The bench forces this by placing idle, extend and error half-words directly after a lone payload half-word. It also mixes such half-words into a long random stream. A behavioural model compares the class, the strobe, the marker, the word and both flags on every clock, so a dropped pair or an early marker shows up in the exact cycle where it goes wrong.

// File: rtl/lfd_pkg.sv
// Package: shared types for the link frame realigning demultiplexer.
// Assumes the two status pins are sampled on the same edge as the data.
package lfd_pkg;
    // Class of one received half-word, coded as seen on the link_class port
    typedef enum logic [1:0] {
        CLS_IDLE = 2'd0,
        CLS_DATA = 2'd1,
        CLS_EXT  = 2'd2,
        CLS_ERR  = 2'd3
    } lfd_class_e;

    // Alignment state of the frame tracker
    typedef enum logic [1:0] {
        MODE_WAIT  = 2'd0,
        MODE_ARMED = 2'd1,
        MODE_RUN   = 2'd2
    } lfd_mode_e;
endpackage

// File: rtl/lfd_status_decode.sv
// Module: lfd_status_decode
// Classifies one received half-word from the two status pins and checks
// whether an idle or carrier-extend half-word carries its expected code.
// Purely combinational; assumes inputs are stable around the sampling edge.
module lfd_status_decode
    import lfd_pkg::*;
#(
    parameter int                 FRAME_W  = 16,
    parameter logic [FRAME_W-1:0] IDLE_A   = 'hBCC5,
    parameter logic [FRAME_W-1:0] IDLE_B   = 'hBC50,
    parameter logic [FRAME_W-1:0] EXT_CODE = 'hF7F7
) (
    input  logic [FRAME_W-1:0] rxd,
    input  logic               rx_dv,
    input  logic               rx_er,
    output lfd_class_e         cls,
    output logic               pat_bad
);
    // Map the pin pair onto a half-word class
    always_comb begin
        unique case ({rx_dv, rx_er})
            2'b00:   cls = CLS_IDLE;
            2'b10:   cls = CLS_DATA;
            2'b01:   cls = CLS_EXT;
            default: cls = CLS_ERR;
        endcase
    end

    // Flag control half-words whose data differs from the fixed codes (R10)
    always_comb begin
        pat_bad = 1'b0;
        if (cls == CLS_IDLE)
            pat_bad = (rxd != IDLE_A) && (rxd != IDLE_B);
        else if (cls == CLS_EXT)
            pat_bad = (rxd != EXT_CODE);
    end
endmodule

// File: rtl/lfd_frame_tracker.sv
// Module: lfd_frame_tracker
// Holds the frame alignment state. Waits for idle after reset, arms on idle,
// and steers each payload half-word to the frame 1 or frame 2 slot.
// Non-payload half-words inside a pair cancel the pair.
// Assumes the class input was decoded from the current inputs.
module lfd_frame_tracker
    import lfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  lfd_class_e cls,
    output logic       take_fr1,
    output logic       take_fr2,
    output logic       bc0_mark,
    output logic       pair_broken
);
    lfd_mode_e mode_q;
    logic      half_q;
    logic      bc0_pend_q;

    // Steering decisions for the current half-word
    always_comb begin
        take_fr1    = (cls == CLS_DATA) && (mode_q != MODE_WAIT) && !half_q;
        take_fr2    = (cls == CLS_DATA) && half_q;
        bc0_mark    = bc0_pend_q;
        pair_broken = (cls == CLS_EXT) && half_q;
    end

    // Alignment mode: idle arms, the first payload after arming enters run
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_WAIT;
        else if (cls == CLS_IDLE)
            mode_q <= MODE_ARMED;
        else if (take_fr1 && mode_q == MODE_ARMED)
            mode_q <= MODE_RUN;
    end

    // Half-pair flag: set by frame 1, cleared by frame 2 or any non-payload
    always_ff @(posedge clk) begin
        if (!rst_n)
            half_q <= 1'b0;
        else if (take_fr1)
            half_q <= 1'b1;
        else if (take_fr2 || cls != CLS_DATA)
            half_q <= 1'b0;
    end

    // Crossing-zero pending: raised on the first frame after arming
    always_ff @(posedge clk) begin
        if (!rst_n)
            bc0_pend_q <= 1'b0;
        else if (take_fr1 && mode_q == MODE_ARMED)
            bc0_pend_q <= 1'b1;
        else if (take_fr2)
            bc0_pend_q <= 1'b0;
    end

    // A frame 2 is only ever taken while aligned and running (R3)
    assert_fr2_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_fr2 |-> (mode_q == MODE_RUN));

    // Idle clears any held half and re-arms alignment (R6)
    assert_idle_rearms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_IDLE) |=> (!half_q && mode_q == MODE_ARMED));
endmodule

// File: rtl/lfd_pair_builder.sv
// Module: lfd_pair_builder
// Holds frame 1 and joins it with frame 2 into one output word with a
// one-cycle strobe and the crossing-zero marker.
// Assumes take_fr1 and take_fr2 are never high together.
module lfd_pair_builder #(
    parameter int FRAME_W = 16,
    localparam int WORD_W = 2 * FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] rxd,
    input  logic               take_fr1,
    input  logic               take_fr2,
    input  logic               bc0_mark,
    output logic [WORD_W-1:0]  word_data,
    output logic               word_valid,
    output logic               word_bc0
);
    logic [FRAME_W-1:0] fr1_q;

    // Capture frame 1 of a pair
    always_ff @(posedge clk) begin
        if (!rst_n)
            fr1_q <= '0;
        else if (take_fr1)
            fr1_q <= rxd;
    end

    // Present the joined word, frame 1 in the upper half
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_data <= '0;
        else if (take_fr2)
            word_data <= {fr1_q, rxd};
    end

    // One-cycle strobe and marker for each completed pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_valid <= 1'b0;
            word_bc0   <= 1'b0;
        end else begin
            word_valid <= take_fr2;
            word_bc0   <= take_fr2 && bc0_mark;
        end
    end

    // The steering logic must never ask for both slots at once (R3)
    assert_slots_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(take_fr1 && take_fr2));
endmodule

// File: rtl/link_frame_demux.sv
// Module: link_frame_demux (top)
// Rebuilds 32-bit crossing words from pairs of 16-bit link half-words.
// Frame phase comes from the idle-to-payload transition on the status pins.
// Also reports the half-word class and keeps sticky error and code flags.
// Assumes all inputs are synchronous to clk, the recovered receive clock.
module link_frame_demux
    import lfd_pkg::*;
#(
    parameter int                 FRAME_W  = 16,
    parameter logic [FRAME_W-1:0] IDLE_A   = 'hBCC5,
    parameter logic [FRAME_W-1:0] IDLE_B   = 'hBC50,
    parameter logic [FRAME_W-1:0] EXT_CODE = 'hF7F7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [FRAME_W-1:0]   rxd,
    input  logic                 rx_dv,
    input  logic                 rx_er,
    output logic [1:0]           link_class,
    output logic [2*FRAME_W-1:0] word_data,
    output logic                 word_valid,
    output logic                 word_bc0,
    output logic                 err_sticky,
    output logic                 code_sticky
);
    lfd_class_e cls;
    logic       pat_bad;
    logic       take_fr1;
    logic       take_fr2;
    logic       bc0_mark;
    logic       pair_broken;

    lfd_status_decode #(
        .FRAME_W (FRAME_W),
        .IDLE_A  (IDLE_A),
        .IDLE_B  (IDLE_B),
        .EXT_CODE(EXT_CODE)
    ) u_decode (
        .rxd    (rxd),
        .rx_dv  (rx_dv),
        .rx_er  (rx_er),
        .cls    (cls),
        .pat_bad(pat_bad)
    );

    lfd_frame_tracker u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cls        (cls),
        .take_fr1   (take_fr1),
        .take_fr2   (take_fr2),
        .bc0_mark   (bc0_mark),
        .pair_broken(pair_broken)
    );

    lfd_pair_builder #(
        .FRAME_W(FRAME_W)
    ) u_builder (
        .clk       (clk),
        .rst_n     (rst_n),
        .rxd       (rxd),
        .take_fr1  (take_fr1),
        .take_fr2  (take_fr2),
        .bc0_mark  (bc0_mark),
        .word_data (word_data),
        .word_valid(word_valid),
        .word_bc0  (word_bc0)
    );

    // Register the class of each sampled half-word (R1)
    always_ff @(posedge clk) begin
        if (!rst_n)
            link_class <= 2'd0;
        else
            link_class <= cls;
    end

    // Sticky link-error flag: error half-words and broken pairs (R7, R8, R9)
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_sticky <= 1'b0;
        else if (cls == CLS_ERR || pair_broken)
            err_sticky <= 1'b1;
    end

    // Sticky code-mismatch flag for idle and extend content (R10)
    always_ff @(posedge clk) begin
        if (!rst_n)
            code_sticky <= 1'b0;
        else if (pat_bad)
            code_sticky <= 1'b1;
    end

    assert_err_word_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && rx_er) |=> err_sticky);

    assert_err_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    assert_code_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        code_sticky |=> code_sticky);

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_bc0_with_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_bc0 |-> word_valid);

    assert_idle_no_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_dv && !rx_er) |=> !word_valid);

    assert_class_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && !rx_er) |=> (link_class == 2'd1));
endmodule

// File: tb/test_link_frame_demux.sv
// Bench for link_frame_demux: a behavioural model (queue of held frames,
// integer alignment mode) is stepped on every clock and compared with all
// outputs half a cycle after each edge.
module test_link_frame_demux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rxd = 16'h0;
    logic        rx_dv = 1'b0;
    logic        rx_er = 1'b0;
    logic [1:0]  link_class;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_bc0;
    logic        err_sticky;
    logic        code_sticky;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // Model state
    int          m_mode = 0;   // 0 wait for idle, 1 armed, 2 running
    logic [15:0] m_held[$];
    bit          m_bc0p = 1'b0;
    logic [1:0]  e_class = 2'd0;
    logic [31:0] e_data = 32'h0;
    bit          e_valid = 1'b0;
    bit          e_bc0 = 1'b0;
    bit          e_err = 1'b0;
    bit          e_code = 1'b0;

    always #4 clk = ~clk;

    link_frame_demux i_link_frame_demux (
        .clk        (clk),
        .rst_n      (rst_n),
        .rxd        (rxd),
        .rx_dv      (rx_dv),
        .rx_er      (rx_er),
        .link_class (link_class),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_bc0   (word_bc0),
        .err_sticky (err_sticky),
        .code_sticky(code_sticky)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        check(link_class == e_class, "R1 class", 32'(link_class), 32'(e_class));
        check(word_valid == e_valid, "R3 valid", 32'(word_valid), 32'(e_valid));
        if (e_valid)
            check(word_data == e_data, "R3 word", word_data, e_data);
        check(word_bc0 == e_bc0, "R4 bc0", 32'(word_bc0), 32'(e_bc0));
        check(err_sticky == e_err, "R8 err_sticky", 32'(err_sticky), 32'(e_err));
        check(code_sticky == e_code, "R10 code_sticky", 32'(code_sticky), 32'(e_code));
    endtask

    task automatic model_reset();
        m_mode = 0;
        m_held.delete();
        m_bc0p = 1'b0;
        e_class = 2'd0;
        e_data = 32'h0;
        e_valid = 1'b0;
        e_bc0 = 1'b0;
        e_err = 1'b0;
        e_code = 1'b0;
    endtask

    task automatic model_step(input bit dv, input bit er, input logic [15:0] d);
        e_valid = 1'b0;
        e_bc0 = 1'b0;
        if (!dv && !er) begin
            e_class = 2'd0;
            if (d != 16'hBCC5 && d != 16'hBC50) e_code = 1'b1;
            m_mode = 1;
            m_held.delete();
        end else if (dv && !er) begin
            e_class = 2'd1;
            if (m_mode != 0) begin
                if (m_held.size() == 0) begin
                    m_held.push_back(d);
                    if (m_mode == 1) begin
                        m_bc0p = 1'b1;
                        m_mode = 2;
                    end
                end else begin
                    e_data = {m_held.pop_front(), d};
                    e_valid = 1'b1;
                    e_bc0 = m_bc0p;
                    m_bc0p = 1'b0;
                end
            end
        end else if (!dv && er) begin
            e_class = 2'd2;
            if (d != 16'hF7F7) e_code = 1'b1;
            if (m_held.size() != 0) begin
                e_err = 1'b1;
                m_held.delete();
            end
        end else begin
            e_class = 2'd3;
            e_err = 1'b1;
            m_held.delete();
        end
    endtask

    // Drive one half-word at a falling edge, step the model, compare next fall
    task automatic step(input bit dv, input bit er, input logic [15:0] d);
        rx_dv = dv;
        rx_er = er;
        rxd = d;
        @(posedge clk);
        model_step(dv, er, d);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_dv = 1'b0;
        rx_er = 1'b0;
        rxd = 16'hBCC5;
        repeat (2) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        compare_all();   // R11: every output cleared by reset
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, (i % 2) ? 16'hBC50 : 16'hBCC5);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R11: a second reset with junk on the pins still clears everything
        step(1'b1, 1'b1, 16'h1111);
        do_reset();

        // R2: payload before any idle is ignored
        step(1'b1, 1'b0, 16'hAAAA);
        step(1'b1, 1'b0, 16'hBBBB);
        step(1'b1, 1'b0, 16'hCCCC);

        // R3, R4, R5: arm with idle, then several pairs
        idle(3);
        step(1'b1, 1'b0, 16'h1234);
        step(1'b1, 1'b0, 16'h5678);   // first word, bc0 set
        step(1'b1, 1'b0, 16'h9ABC);
        step(1'b1, 1'b0, 16'hDEF0);   // bc0 clear
        // R5: carrier extend between pairs keeps pairing
        step(1'b0, 1'b1, 16'hF7F7);
        step(1'b1, 1'b0, 16'h0F0F);
        step(1'b1, 1'b0, 16'hF0F0);

        // R6: idle in the frame 2 slot re-arms, no error
        step(1'b1, 1'b0, 16'h4444);
        idle(1);
        step(1'b1, 1'b0, 16'h5555);
        step(1'b1, 1'b0, 16'h6666);   // bc0 again

        // R7: extend in the frame 2 slot breaks the pair and flags
        step(1'b1, 1'b0, 16'h7777);
        step(1'b0, 1'b1, 16'hF7F7);
        step(1'b1, 1'b0, 16'h8888);
        step(1'b1, 1'b0, 16'h9999);   // new pair, no bc0

        // R9: sticky survives idle stretches and payload
        idle(5);
        step(1'b1, 1'b0, 16'h1010);
        step(1'b1, 1'b0, 16'h2020);

        // R8: error half-word clears err after reset, flags, breaks pair
        do_reset();
        idle(2);
        step(1'b1, 1'b0, 16'h3030);
        step(1'b1, 1'b1, 16'h1234);   // R10: error data never sets code flag
        step(1'b1, 1'b0, 16'h4040);
        step(1'b1, 1'b0, 16'h5050);
        step(1'b1, 1'b1, 16'hFEFE);   // error between pairs

        // R10: bad idle content, then bad extend content after reset
        idle(1);
        step(1'b0, 1'b0, 16'h0BAD);
        do_reset();
        step(1'b0, 1'b1, 16'hF7F6);
        do_reset();
        step(1'b1, 1'b0, 16'hBCC6);   // payload content is never checked

        // Mixed random stream, mostly payload
        idle(3);
        for (int i = 0; i < 400; i++) begin
            int r;
            logic [15:0] d;
            r = $urandom_range(0, 19);
            d = 16'($urandom);
            if (r < 13)       step(1'b1, 1'b0, d);
            else if (r < 16)  step(1'b0, 1'b0, (r == 15) ? d : 16'hBC50);
            else if (r < 18)  step(1'b0, 1'b1, (r == 17) ? d : 16'hF7F7);
            else              step(1'b1, 1'b1, 16'hFEFE);
            if (i == 200) do_reset();
        end
        finish_run();
    end
endmodule